// File: doc/BRIEF.md
# Bus-Master DMA Control Register Block

This block holds the control registers of one bus-master DMA channel of a disk controller: a command byte, a status byte and a 32-bit descriptor-table base address. The host reaches them through a byte-addressed register port with 1-, 2- and 4-byte accesses. Command writes become single-cycle control pulses for a separate descriptor walker:
- a rewind pulse tells the walker to reload its table pointer from the base,
- a start pulse tells it to begin a transfer,
- a cancel pulse aborts one.

The block tracks whether DMA is active and updates that flag when the walker reports completion. It records walker errors. It latches the drive's interrupt line into a status bit while passing that line straight through to the host.

The register port is plain strobed control, not a data stream, so it has no valid/ready handshake. A write is accepted in the cycle its strobe is high. A read returns its data one cycle after its strobe. The walker accepts pulses without back-pressure.

Register layout, by byte offset:
- Offset 0: command.
- Offset 1: status.
- Offsets 4 to 7: table base, least significant byte at 4.
- Offsets 2 and 3: read as zero and ignore writes.

The access size field `acc_size` encodes the access width: 0 means 1 byte, 1 means 2 bytes, and 2 or 3 means 4 bytes. An access covers the bytes from its offset upward, and bytes past offset 7 are dropped.

Top module: `bm_dma_regs`

## Requirements
- R1: A command write whose bit 0 is 1 while the stored bit 0 is 0 raises `rewind_pulse` for one cycle. If `dma_active` was 0, it also sets `dma_active` and raises `start_pulse` for one cycle. If `dma_active` was already 1, `start_pulse` stays low. All of these are visible the cycle after the write.
- R2: A command write whose bit 0 is 0 while the stored bit 0 is 1 raises `cancel_pulse` for one cycle and clears `dma_active`.
- R3: A command write whose bit 0 equals the stored bit 0 produces no pulse and leaves `dma_active` unchanged.
- R4: The stored command is the written byte ANDed with 0x09, so only bit 0 (start) and bit 3 (direction) are kept. `dir_to_mem` shows bit 3.
- R5: The table base takes writes at offsets 4 to 7 of any size. Only the addressed bytes change, and bits 1:0 always read as zero.
- R6: A read returns the 8-byte register window shifted down by its offset and masked to the access width, on `rd_data` the cycle after `rd_en`. Status bit 0 reads `dma_active`, bit 1 reads error and bit 2 reads interrupt.
- R7: While `drive_irq` is high, status bit 2 is set at each clock edge. `host_irq` equals `drive_irq` in the same cycle, and a low level leaves status bit 2 unchanged.
- R8: Writing 1 to status bit 1 or bit 2 clears that bit. Status bit 0 ignores writes.
- R9: A cycle with `walk_done` high sets `dma_active` to `walk_more`. A command write in the same cycle that changes bit 0 takes precedence.
- R10: A cycle with `walk_err` high sets status bit 1.
- R11: Reset clears the command, status, table base and `dma_active`, and holds all pulses low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| reg_off | input | 3 | Byte offset of the access |
| acc_size | input | 2 | Access width: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes |
| wr_data | input | 32 | Write data, least significant byte at `reg_off` |
| rd_data | output | 32 | Read data, valid the cycle after `rd_en` |
| drive_irq | input | 1 | Interrupt level from the drive |
| walk_done | input | 1 | Walker finished its current run |
| walk_more | input | 1 | With `walk_done`: more data is still pending |
| walk_err | input | 1 | Walker reports a transfer error |
| start_pulse | output | 1 | One-cycle transfer kick to the walker |
| rewind_pulse | output | 1 | One-cycle table pointer reload |
| cancel_pulse | output | 1 | One-cycle transfer abort |
| dma_active | output | 1 | DMA-active flag |
| dir_to_mem | output | 1 | Stored direction bit |
| table_base | output | 32 | Descriptor-table base address |
| host_irq | output | 1 | Interrupt level passed through to the host |

## Verification
Register writes, walker strobes and drive-interrupt edges all update state at the clock edge that samples them. The resulting pulses and flags therefore show one cycle after the stimulus and last exactly one cycle. Read data is registered, so it appears one cycle after `rd_en`. `host_irq` is the only result that is combinational, and it follows `drive_irq` within the same cycle. The bench applies every stimulus at a falling edge. It samples registered results at the next falling edge, which is half a period after the edge that captured them, and it samples `host_irq` just after the drive change.

// File: rtl/bm_pkg.sv
package bm_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  // number of bytes covered by an access size code
  function automatic logic [3:0] size_bytes(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: size_bytes = 4'd1;
      SZ_HALF: size_bytes = 4'd2;
      default: size_bytes = 4'd4;
    endcase
  endfunction
endpackage

// File: rtl/bm_lane_dec.sv
module bm_lane_dec
  import bm_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int DATA_W = 32,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic                 wr_en,
  input  logic [OFF_W-1:0]     offset,
  input  logic [1:0]           size,
  input  logic [DATA_W-1:0]    wdata,
  output logic [LANES-1:0]     lane_we,
  output logic [8*LANES-1:0]   lane_data
);
  logic [OFF_W:0] first_lane;
  logic [OFF_W:0] end_lane;

  assign first_lane = {1'b0, offset};
  assign end_lane   = first_lane + (OFF_W+1)'(size_bytes(size));

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_we[k] = wr_en && ((OFF_W+1)'(k) >= first_lane) &&
                        ((OFF_W+1)'(k) < end_lane);
  end

  assign lane_data = (8*LANES)'(wdata) << {offset, 3'b000};
endmodule

// File: rtl/bm_base_reg.sv
module bm_base_reg #(
  parameter int ADDR_W = 32,
  localparam int NB = ADDR_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NB-1:0]     lane_we,
  input  logic [ADDR_W-1:0] lane_data,
  output logic [ADDR_W-1:0] base
);
  for (genvar k = 0; k < NB; k++) begin : g_byte
    localparam logic [7:0] KEEP = (k == 0) ? 8'hFC : 8'hFF;
    always_ff @(posedge clk) begin
      if (!rst_n)
        base[8*k +: 8] <= '0;
      else if (lane_we[k])
        base[8*k +: 8] <= lane_data[8*k +: 8] & KEEP;
    end
  end

  // R5
  untouched_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_we == '0) |=> $stable(base));
endmodule

// File: rtl/bm_cmd_ctl.sv
module bm_cmd_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_we,
  input  logic [7:0] cmd_byte,
  input  logic       sts_we,
  input  logic [1:0] sts_clr,     // {clear irq, clear err}
  input  logic       walk_done,
  input  logic       walk_more,
  input  logic       walk_err,
  input  logic       drive_irq,
  output logic [7:0] cmd_q,
  output logic [7:0] sts_q,
  output logic       start_pulse,
  output logic       rewind_pulse,
  output logic       cancel_pulse
);
  localparam logic [7:0] CMD_KEEP = 8'h09;

  logic active_q, err_q, irq_q;
  logic start_edge;

  assign start_edge = cmd_we && (cmd_byte[0] != cmd_q[0]);
  assign sts_q      = {5'b0, irq_q, err_q, active_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q        <= '0;
      active_q     <= 1'b0;
      err_q        <= 1'b0;
      irq_q        <= 1'b0;
      start_pulse  <= 1'b0;
      rewind_pulse <= 1'b0;
      cancel_pulse <= 1'b0;
    end else begin
      start_pulse  <= 1'b0;
      rewind_pulse <= 1'b0;
      cancel_pulse <= 1'b0;

      if (walk_done) active_q <= walk_more;

      if (walk_err)                   err_q <= 1'b1;
      else if (sts_we && sts_clr[0])  err_q <= 1'b0;

      if (drive_irq)                  irq_q <= 1'b1;
      else if (sts_we && sts_clr[1])  irq_q <= 1'b0;

      if (cmd_we) cmd_q <= cmd_byte & CMD_KEEP;

      if (start_edge) begin
        if (!cmd_byte[0]) begin
          active_q     <= 1'b0;
          cancel_pulse <= 1'b1;
        end else begin
          rewind_pulse <= 1'b1;
          if (!active_q) begin
            active_q    <= 1'b1;
            start_pulse <= 1'b1;
          end
        end
      end
    end
  end

  // R1
  start_sets_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> (active_q && rewind_pulse && cmd_q[0]));
  // R1
  start_only_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_byte[0] && !cmd_q[0] && active_q) |=> !start_pulse);
  // R2
  cancel_clears_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_pulse |-> (!active_q && !cmd_q[0] && !rewind_pulse));
  // R3
  same_start_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && (cmd_byte[0] == cmd_q[0])) |=>
      !(start_pulse || rewind_pulse || cancel_pulse));
  // R7
  irq_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drive_irq |=> irq_q);
  // R9
  walk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_done && !walk_more && !cmd_we) |=> !active_q);
  // R10
  err_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_err |=> err_q);
  // R2
  one_pulse_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_pulse, cancel_pulse}));
endmodule

// File: rtl/bm_dma_regs.sv
module bm_dma_regs #(
  parameter int ADDR_W    = 32,
  parameter int LANES     = 8,
  parameter int CMD_LANE  = 0,
  parameter int STS_LANE  = 1,
  parameter int BASE_LANE = 4,
  localparam int OFF_W    = $clog2(LANES),
  localparam int NB       = ADDR_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [OFF_W-1:0]  reg_off,
  input  logic [1:0]        acc_size,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  input  logic              drive_irq,
  input  logic              walk_done,
  input  logic              walk_more,
  input  logic              walk_err,
  output logic              start_pulse,
  output logic              rewind_pulse,
  output logic              cancel_pulse,
  output logic              dma_active,
  output logic              dir_to_mem,
  output logic [ADDR_W-1:0] table_base,
  output logic              host_irq
);
  logic [LANES-1:0]   lane_we;
  logic [8*LANES-1:0] lane_data;
  logic [7:0]         cmd_q, sts_q;
  logic [8*LANES-1:0] window;
  logic [31:0]        shifted;
  logic               unused_bits;

  bm_lane_dec #(.LANES(LANES), .DATA_W(32)) i_dec (
    .wr_en    (wr_en),
    .offset   (reg_off),
    .size     (acc_size),
    .wdata    (wr_data),
    .lane_we  (lane_we),
    .lane_data(lane_data)
  );

  bm_cmd_ctl i_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_we      (lane_we[CMD_LANE]),
    .cmd_byte    (lane_data[8*CMD_LANE +: 8]),
    .sts_we      (lane_we[STS_LANE]),
    .sts_clr     ({lane_data[8*STS_LANE+2], lane_data[8*STS_LANE+1]}),
    .walk_done   (walk_done),
    .walk_more   (walk_more),
    .walk_err    (walk_err),
    .drive_irq   (drive_irq),
    .cmd_q       (cmd_q),
    .sts_q       (sts_q),
    .start_pulse (start_pulse),
    .rewind_pulse(rewind_pulse),
    .cancel_pulse(cancel_pulse)
  );

  bm_base_reg #(.ADDR_W(ADDR_W)) i_base (
    .clk      (clk),
    .rst_n    (rst_n),
    .lane_we  (lane_we[BASE_LANE +: NB]),
    .lane_data(lane_data[8*BASE_LANE +: ADDR_W]),
    .base     (table_base)
  );

  assign dma_active = sts_q[0];
  assign dir_to_mem = cmd_q[3];
  assign host_irq   = drive_irq;

  always_comb begin
    window = '0;
    window[8*CMD_LANE +: 8]       = cmd_q;
    window[8*STS_LANE +: 8]       = sts_q;
    window[8*BASE_LANE +: ADDR_W] = table_base;
  end

  assign shifted = 32'(window >> {reg_off, 3'b000});

  always_ff @(posedge clk) begin
    if (!rst_n)
      rd_data <= '0;
    else if (rd_en)
      case (acc_size)
        2'd0:    rd_data <= {24'b0, shifted[7:0]};
        2'd1:    rd_data <= {16'b0, shifted[15:0]};
        default: rd_data <= shifted;
      endcase
  end

  assign unused_bits = ^{lane_we[3:2], lane_data[31:16], lane_data[15:11],
                         lane_data[8]};

  // R6
  read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
  // R7
  irq_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq == drive_irq);
  // R5
  base_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    table_base[1:0] == 2'b00);
endmodule

// File: tb/test_bm_dma_regs.sv
module test_bm_dma_regs;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, rd_en = 0;
  logic [2:0] reg_off = '0;
  logic [1:0] acc_size = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic drive_irq = 0, walk_done = 0, walk_more = 0, walk_err = 0;
  logic start_pulse, rewind_pulse, cancel_pulse, dma_active, dir_to_mem, host_irq;
  logic [31:0] table_base;
  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  bm_dma_regs i_bm_dma_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .reg_off(reg_off), .acc_size(acc_size), .wr_data(wr_data),
    .rd_data(rd_data), .drive_irq(drive_irq), .walk_done(walk_done),
    .walk_more(walk_more), .walk_err(walk_err), .start_pulse(start_pulse),
    .rewind_pulse(rewind_pulse), .cancel_pulse(cancel_pulse),
    .dma_active(dma_active), .dir_to_mem(dir_to_mem),
    .table_base(table_base), .host_irq(host_irq)
  );

  typedef struct packed {
    logic        is_rd;
    logic [2:0]  off;
    logic [1:0]  sz;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 3'd4, 2'd2, 32'h12345677, 32'h0, 4'd5},   // R5 word write
    '{1'b1, 3'd4, 2'd2, 32'h0, 32'h12345674, 4'd5},   // R5 low bits zero
    '{1'b0, 3'd5, 2'd0, 32'h000000AB, 32'h0, 4'd5},   // R5 one lane
    '{1'b1, 3'd5, 2'd1, 32'h0, 32'h000034AB, 4'd6},   // R6 half read
    '{1'b1, 3'd4, 2'd0, 32'h0, 32'h00000074, 4'd6},   // R6 byte read
    '{1'b0, 3'd4, 2'd1, 32'h0000FFFF, 32'h0, 4'd5},   // R5 half write
    '{1'b1, 3'd4, 2'd2, 32'h0, 32'h1234FFFC, 4'd5},
    '{1'b0, 3'd0, 2'd0, 32'h000000FF, 32'h0, 4'd4},   // R4 mask 0x09
    '{1'b1, 3'd0, 2'd0, 32'h0, 32'h00000009, 4'd4},
    '{1'b1, 3'd0, 2'd2, 32'h0, 32'h00000109, 4'd6},   // R6 cmd+status
    '{1'b0, 3'd0, 2'd0, 32'h00000000, 32'h0, 4'd2},   // R2 stop
    '{1'b1, 3'd0, 2'd1, 32'h0, 32'h00000000, 4'd2},
    '{1'b0, 3'd6, 2'd2, 32'h0000AABB, 32'h0, 4'd5},   // R5 spill past top
    '{1'b1, 3'd4, 2'd2, 32'h0, 32'hAABBFFFC, 4'd5},
    '{1'b1, 3'd7, 2'd0, 32'h0, 32'h000000AA, 4'd6}
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_wr(input logic [2:0] off, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; reg_off = off; acc_size = sz; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic do_rd(input logic [2:0] off, input logic [1:0] sz, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1; reg_off = off; acc_size = sz;
    @(negedge clk);
    rd_en = 0;
    d = rd_data;
  endtask

  task automatic do_walk(input logic more, input logic err);
    @(negedge clk);
    walk_done = !err; walk_more = more; walk_err = err;
    @(negedge clk);
    walk_done = 0; walk_more = 0; walk_err = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    do_reset();
    // R11 reset state
    check("R11 pulses", {29'b0, start_pulse, rewind_pulse, cancel_pulse}, 32'h0);
    check("R11 active", {31'b0, dma_active}, 32'h0);
    check("R11 base", table_base, 32'h0);
    do_rd(3'd0, 2'd2, r); check("R11 cmd/status", r, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].is_rd) begin
        do_rd(VEC[i].off, VEC[i].sz, r);
        check($sformatf("R%0d vec%0d", VEC[i].req, i), r, VEC[i].exp);
      end else begin
        do_wr(VEC[i].off, VEC[i].sz, VEC[i].data);
      end
    end
    check("R5 base port", table_base, 32'hAABBFFFC);

    // R1 start edge while idle
    do_wr(3'd0, 2'd0, 32'h01);
    check("R1 start/rewind/cancel", {29'b0, start_pulse, rewind_pulse, cancel_pulse}, 32'h6);
    check("R1 active", {31'b0, dma_active}, 32'h1);
    @(negedge clk);
    check("R1 single cycle", {29'b0, start_pulse, rewind_pulse, cancel_pulse}, 32'h0);
    // R3 same start value again, then direction change only
    do_wr(3'd0, 2'd0, 32'h01);
    check("R3 rewrite pulses", {29'b0, start_pulse, rewind_pulse, cancel_pulse}, 32'h0);
    do_wr(3'd0, 2'd0, 32'h09);
    check("R3 dir-only pulses", {29'b0, start_pulse, rewind_pulse, cancel_pulse}, 32'h0);
    check("R4 dir_to_mem", {31'b0, dir_to_mem}, 32'h1);
    check("R3 active kept", {31'b0, dma_active}, 32'h1);
    // R9 walker done
    do_walk(1'b1, 1'b0);
    check("R9 more keeps active", {31'b0, dma_active}, 32'h1);
    do_walk(1'b0, 1'b0);
    check("R9 done clears active", {31'b0, dma_active}, 32'h0);
    do_wr(3'd0, 2'd0, 32'h09);
    check("R3 no restart", {30'b0, start_pulse, dma_active}, 32'h0);
    // R2 stop with active already clear
    do_wr(3'd0, 2'd0, 32'h00);
    check("R2 cancel", {29'b0, start_pulse, rewind_pulse, cancel_pulse}, 32'h1);
    // R1 start edge while already active: rewind only
    do_walk(1'b1, 1'b0);
    do_wr(3'd0, 2'd0, 32'h01);
    check("R1 rewind only", {29'b0, start_pulse, rewind_pulse, cancel_pulse}, 32'h2);
    // R9 precedence: stop write with walk_done+more in same cycle
    @(negedge clk);
    wr_en = 1; reg_off = 3'd0; acc_size = 2'd0; wr_data = 32'h0;
    walk_done = 1; walk_more = 1;
    @(negedge clk);
    wr_en = 0; walk_done = 0; walk_more = 0;
    check("R9 cmd wins", {30'b0, cancel_pulse, dma_active}, 32'h2);

    // R7 interrupt level
    @(negedge clk); drive_irq = 1; #1;
    check("R7 host_irq high", {31'b0, host_irq}, 32'h1);
    @(negedge clk); drive_irq = 0; #1;
    check("R7 host_irq low", {31'b0, host_irq}, 32'h0);
    do_rd(3'd1, 2'd0, r); check("R7 status irq held", r, 32'h04);
    // R10 error
    do_walk(1'b0, 1'b1);
    do_rd(3'd1, 2'd0, r); check("R10 status err", r, 32'h06);
    // R8 write-one-to-clear
    do_wr(3'd1, 2'd0, 32'h04);
    do_rd(3'd1, 2'd0, r); check("R8 clear irq", r, 32'h02);
    do_wr(3'd1, 2'd0, 32'h02);
    do_rd(3'd1, 2'd0, r); check("R8 clear err", r, 32'h00);
    do_walk(1'b1, 1'b0);
    do_wr(3'd1, 2'd0, 32'h01);
    do_rd(3'd1, 2'd0, r); check("R8 active read-only", r, 32'h01);

    // R11 reset while active
    do_wr(3'd4, 2'd2, 32'hCAFE0004);
    do_reset();
    check("R11 active after reset", {31'b0, dma_active}, 32'h0);
    check("R11 base after reset", table_base, 32'h0);
    do_rd(3'd0, 2'd2, r); check("R11 regs after reset", r, 32'h0);
    finish_run();
  end
endmodule